// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps wall-clock time as one 32-bit count of seconds and raises an alarm interrupt when that count reaches a programmed value. It advances by one on each cycle in which the one-second tick input is high and counting is enabled. Software reaches every register through an 8-bit bus. Each access moves a single byte, so no multi-byte value is ever transferred atomically.

The counter is loaded through a write-only window and observed through a separate read window. The read window shows the live count with no snapshot. A 32-bit compare value sits in its own window. When the alarm is enabled and the count changes to equal that value, a pending flag is set. The interrupt output is that flag, so it rises when the alarm fires and stays high until software writes zero to the flag.

Because the bus is byte-wide, two access orders matter. To load the counter, software first zeroes byte 0, then writes bytes 1 to 3, and writes the real byte 0 last. This keeps a carry out of byte 0 from corrupting the upper bytes while they are being written. To read the counter, software reads byte 0 again after the upper bytes. If the second value is smaller than the first, a carry happened between the reads and the read must be repeated.

Top module: `rtc_top`

## Requirements
- R1: After reset, the counter, the compare value, all control bits and the pending flag are zero, so every address reads 0x00 and `alarmIrq` is low.
- R2: While control bit 7 is set, each cycle with `tickIn` high adds one to the counter. While bit 7 is clear, the counter holds its value.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 and sets no flag in doing so, even when the alarm is enabled with a compare value other than zero.
- R4: A write to address 0x02+k (k = 0..3, byte 0 being the least significant) replaces byte k of the counter at that clock edge. Any tick in that cycle is dropped. These addresses read 0x00.
- R5: Address 0x06+k returns byte k of the live counter, combinationally from the address.
- R6: The control register at 0x00 stores bit 7 (run), bit 1 (alarm enable) and bit 0 (abort enable) and reads them back. Its other bits read 0.
- R7: Addresses 0x0A+k hold byte k of the 32-bit compare value and read it back.
- R8: When the alarm is enabled and the counter changes to a value equal to the compare value, bit 0 of address 0x01 becomes 1 at that same edge, and `alarmIrq` rises with it.
- R9: No alarm fires while alarm enable is clear. No alarm fires when the counter already equals the compare value but does not change.
- R10: Writing a byte with bit 0 = 0 to address 0x01 clears the pending flag and lowers `alarmIrq`. Writing bit 0 = 1 leaves the flag unchanged.
- R11: Addresses 0x0E and 0x0F read 0x00, and writes to them change no state.
- R12: The load order (byte 0 = 0x00, then bytes 1, 2 and 3, then the real byte 0) leaves exactly the target value in the counter, even when ticks arrive in every cycle of the sequence.
- R13: A carry between reading byte 0 and reading the upper bytes shows in the read data: a second read of byte 0 returns a smaller value than the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-second tick; each cycle with it high counts once |
| busAddr | input | ADDR_W (4) | Byte register address |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte for `busAddr`, combinational |
| alarmIrq | output | 1 | Alarm interrupt, level, equal to the pending flag |

## Verification
The hardest situations to reach from the ports are the races between the byte-wide bus and a running counter. These are a tick and a counter-byte write in the same cycle, a carry that lands between two byte reads, and a load sequence that runs while ticks are arriving. The bench holds `tickIn` high across its own bus writes to force the collision and the mid-load carries. It then computes the exact expected count from the number of edges it has driven. For the torn read, it places the counter at a low byte of 0xFF and inserts exactly one tick between two reads. The alarm sweep preloads the counter three below each compare value, including one value where reaching it carries out of the low byte. It then steps single ticks, so the edge at which the flag must rise is known exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTES  = 4;
  localparam int DW     = 8;
  localparam int CW     = BYTES * DW;
  localparam int BSEL_W = $clog2(BYTES);

  // address plan, in byte units from the block base
  localparam int ADR_CTRL  = 0;
  localparam int ADR_ACK   = 1;
  localparam int ADR_LOAD  = 2;
  localparam int ADR_LIVE  = ADR_LOAD + BYTES;
  localparam int ADR_MATCH = ADR_LIVE + BYTES;
  localparam int ADR_END   = ADR_MATCH + BYTES;

  // control register bit positions
  localparam int BIT_RUN = 7;
  localparam int BIT_ALM = 1;
  localparam int BIT_ABT = 0;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_ACK,
    RD_LIVE,
    RD_MATCH
  } rd_sel_e;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrAck;
    logic [BYTES-1:0]  wrLoad;
    logic [BYTES-1:0]  wrMatch;
    rd_sel_e           rdSel;
    logic [BSEL_W-1:0] rdByte;
  } rtc_strobe_t;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output rtc_strobe_t       strb
);
  logic [31:0] addrExt;
  logic [31:0] liveOff;
  logic [31:0] matchOff;
  logic        inLoad;
  logic        inLive;
  logic        inMatch;

  assign addrExt  = 32'(busAddr);
  assign liveOff  = addrExt - 32'(ADR_LIVE);
  assign matchOff = addrExt - 32'(ADR_MATCH);
  assign inLoad   = (addrExt >= 32'(ADR_LOAD))  && (addrExt < 32'(ADR_LIVE));
  assign inLive   = (addrExt >= 32'(ADR_LIVE))  && (addrExt < 32'(ADR_MATCH));
  assign inMatch  = (addrExt >= 32'(ADR_MATCH)) && (addrExt < 32'(ADR_END));

  // one-hot byte write strobes per window
  for (genvar b = 0; b < BYTES; b++) begin : g_byteStrb
    assign strb.wrLoad[b]  = busWe && (addrExt == 32'(ADR_LOAD + b));
    assign strb.wrMatch[b] = busWe && (addrExt == 32'(ADR_MATCH + b));
  end

  assign strb.wrCtrl = busWe && (addrExt == 32'(ADR_CTRL));
  assign strb.wrAck  = busWe && (addrExt == 32'(ADR_ACK));

  always_comb begin
    strb.rdSel  = RD_NONE;
    strb.rdByte = '0;
    if (addrExt == 32'(ADR_CTRL)) begin
      strb.rdSel = RD_CTRL;
    end else if (addrExt == 32'(ADR_ACK)) begin
      strb.rdSel = RD_ACK;
    end else if (inLive) begin
      strb.rdSel  = RD_LIVE;
      strb.rdByte = liveOff[BSEL_W-1:0];
    end else if (inMatch) begin
      strb.rdSel  = RD_MATCH;
      strb.rdByte = matchOff[BSEL_W-1:0];
    end else if (inLoad) begin
      strb.rdSel = RD_NONE;   // load window is write-only
    end
  end
endmodule

// File: rtl/rtc_dpath.sv
module rtc_dpath
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickIn,
  input  logic [DW-1:0] busWdata,
  input  rtc_strobe_t   strb,
  output logic [DW-1:0] busRdata,
  output logic [CW-1:0] cntVal,
  output logic [CW-1:0] almVal,
  output logic          runEn,
  output logic          almEn,
  output logic          abortEn,
  output logic          pendFlag
);
  logic [CW-1:0] cntLoadMix;
  logic [CW-1:0] almNext;
  logic [CW-1:0] cntNext;
  logic          anyLoad;
  logic          stepOk;
  logic          fireNow;

  // byte-wise merge of bus data into counter and compare value
  for (genvar b = 0; b < BYTES; b++) begin : g_byteMix
    assign cntLoadMix[b*DW +: DW] = strb.wrLoad[b]  ? busWdata : cntVal[b*DW +: DW];
    assign almNext[b*DW +: DW]    = strb.wrMatch[b] ? busWdata : almVal[b*DW +: DW];
  end

  assign anyLoad = |strb.wrLoad;
  assign stepOk  = tickIn && runEn;

  always_comb begin
    if (anyLoad)      cntNext = cntLoadMix;     // bus write wins over the tick
    else if (stepOk)  cntNext = cntVal + 1'b1;  // natural wrap at all-ones
    else              cntNext = cntVal;
  end

  assign fireNow = almEn && (cntNext != cntVal) && (cntNext == almVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      almVal   <= '0;
      runEn    <= 1'b0;
      almEn    <= 1'b0;
      abortEn  <= 1'b0;
      pendFlag <= 1'b0;
    end else begin
      cntVal <= cntNext;
      almVal <= almNext;
      if (strb.wrCtrl) begin
        runEn   <= busWdata[BIT_RUN];
        almEn   <= busWdata[BIT_ALM];
        abortEn <= busWdata[BIT_ABT];
      end
      if (fireNow)
        pendFlag <= 1'b1;
      else if (strb.wrAck && !busWdata[0])
        pendFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strb.rdSel)
      RD_CTRL: begin
        busRdata[BIT_RUN] = runEn;
        busRdata[BIT_ALM] = almEn;
        busRdata[BIT_ABT] = abortEn;
      end
      RD_ACK:   busRdata[0] = pendFlag;
      RD_LIVE:  busRdata = cntVal[strb.rdByte*DW +: DW];
      RD_MATCH: busRdata = almVal[strb.rdByte*DW +: DW];
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              alarmIrq
);
  rtc_strobe_t   strb;
  logic [CW-1:0] cntVal;
  logic [CW-1:0] almVal;
  logic          runEn;
  logic          almEn;
  logic          abortEn;
  logic          pendFlag;

  rtc_decode #(.ADDR_W(ADDR_W)) decode_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  rtc_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .busWdata (busWdata),
    .strb     (strb),
    .busRdata (busRdata),
    .cntVal   (cntVal),
    .almVal   (almVal),
    .runEn    (runEn),
    .almEn    (almEn),
    .abortEn  (abortEn),
    .pendFlag (pendFlag)
  );

  assign alarmIrq = pendFlag;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              alarmIrq,
  input logic [CW-1:0]     cntVal,
  input logic [CW-1:0]     almVal,
  input logic              runEn,
  input logic              almEn
);
  logic loadHit;
  assign loadHit = busWe && (32'(busAddr) >= 32'(ADR_LOAD)) && (32'(busAddr) < 32'(ADR_LIVE));

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> ($past(almEn) && (cntVal == almVal) && (cntVal != $past(cntVal)))); // R8

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !almEn |=> !$rose(alarmIrq)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (32'(busAddr) == 32'(ADR_ACK)) && !busWdata[0] && !almEn) |=> !alarmIrq); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(runEn && tickIn) && !loadHit) |=> $stable(cntVal)); // R2

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (32'(busAddr) == 32'(ADR_LOAD))) |=> (cntVal[7:0] == $past(busWdata))); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((cntVal == '1) && runEn && tickIn && !loadHit) |=> (cntVal == '0)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (32'(busAddr) >= 32'(ADR_END)) |-> (busRdata == 8'h00)); // R11
endmodule

bind rtc_top rtc_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickIn   (tickIn),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .alarmIrq (alarmIrq),
  .cntVal   (cntVal),
  .almVal   (almVal),
  .runEn    (runEn),
  .almEn    (almEn)
);

// File: tb/rtc_top_tb_top.sv
module rtc_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       alarmIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  rtc_top #(.ADDR_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #2 d = busRdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickIn = 1'b1;
    repeat (n) @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic loadCnt(input logic [31:0] v);
    wr(4'h2, 8'h00);
    wr(4'h3, v[15:8]);
    wr(4'h4, v[23:16]);
    wr(4'h5, v[31:24]);
    wr(4'h2, v[7:0]);
  endtask

  task automatic setMatch(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(4'(10 + b), v[b*8 +: 8]);
  endtask

  task automatic readCnt(output logic [31:0] v);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(4'(6 + b), d);
      v[b*8 +: 8] = d;
    end
  endtask

  task automatic readMatch(output logic [31:0] v);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(4'(10 + b), d);
      v[b*8 +: 8] = d;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, d0a, d1, d0b;
    logic [31:0] v, exp;
    logic [31:0] pats [6];
    logic [31:0] alms [4];
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001, 32'h00FF_FF00, 32'hA5C3_3C5A};
    alms = '{32'h0000_0010, 32'h0000_0100, 32'hABCD_EF02, 32'h0100_0000};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, every address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset read", 32'(d), 32'h0);
    end
    chk("R1 irq low", 32'(alarmIrq), 32'h0);

    // R6: control bits
    wr(4'h0, 8'hFF); rd(4'h0, d); chk("R6 ctrl FF", 32'(d), 32'h83);
    wr(4'h0, 8'h7C); rd(4'h0, d); chk("R6 ctrl 7C", 32'(d), 32'h00);
    wr(4'h0, 8'h81); rd(4'h0, d); chk("R6 ctrl 81", 32'(d), 32'h81);
    wr(4'h0, 8'h00);

    // R7 and R4/R5: compare and counter round trips, run off
    for (int i = 0; i < 6; i++) begin
      setMatch(pats[i]); readMatch(v); chk("R7 match rw", v, pats[i]);
      loadCnt(pats[i]);  readCnt(v);   chk("R4 R5 load/read", v, pats[i]);
      rd(4'(2 + (i % 4)), d); chk("R4 load window reads 0", 32'(d), 32'h0);
    end
    loadCnt(32'h1122_3344);
    wr(4'h4, 8'h5A); readCnt(v); chk("R4 single byte", v, 32'h115A_3344);

    // R2: run counts, stop holds
    wr(4'h0, 8'h80);
    loadCnt(32'h0000_00F0);
    ticks(37); readCnt(v); chk("R2 count 37", v, 32'h0000_00F0 + 37);
    wr(4'h0, 8'h00);
    ticks(20); readCnt(v); chk("R2 hold", v, 32'h0000_00F0 + 37);

    // R4: tick collides with a byte write, tick dropped
    wr(4'h0, 8'h80);
    loadCnt(32'h0000_0210);
    @(negedge clk);
    tickIn = 1'b1; busAddr = 4'h3; busWdata = 8'h07; busWe = 1'b1;
    @(negedge clk);
    tickIn = 1'b0; busWe = 1'b0;
    readCnt(v); chk("R4 tick suppressed", v, 32'h0000_0710);

    // R3: wrap without alarm
    wr(4'h0, 8'h00);
    loadCnt(32'hFFFF_FFFF);
    setMatch(32'h0000_0005);
    wr(4'h0, 8'h82);
    ticks(1); readCnt(v); chk("R3 wrap", v, 32'h0);
    chk("R3 no flag", 32'(alarmIrq), 32'h0);

    // R8 / R10: alarm sweep
    for (int i = 0; i < 4; i++) begin
      wr(4'h0, 8'h00);
      loadCnt(alms[i] - 3);
      setMatch(alms[i]);
      wr(4'h0, 8'h82);
      ticks(2); chk("R8 not yet", 32'(alarmIrq), 32'h0);
      ticks(1); chk("R8 fire irq", 32'(alarmIrq), 32'h1);
      rd(4'h1, d); chk("R8 status bit", 32'(d), 32'h1);
      readCnt(v); chk("R8 count at match", v, alms[i]);
      wr(4'h1, 8'h01); chk("R10 write 1 keeps", 32'(alarmIrq), 32'h1);
      wr(4'h1, 8'hFE); chk("R10 write 0 clears", 32'(alarmIrq), 32'h0);
      rd(4'h1, d); chk("R10 status cleared", 32'(d), 32'h0);
    end

    // R9: disabled alarm, and enabling while already equal
    wr(4'h0, 8'h80);
    loadCnt(32'h0000_0440);
    setMatch(32'h0000_0441);
    ticks(1); chk("R9 disabled no fire", 32'(alarmIrq), 32'h0);
    wr(4'h0, 8'h82);
    repeat (3) @(negedge clk);
    chk("R9 equal but static", 32'(alarmIrq), 32'h0);
    ticks(1); readCnt(v);
    chk("R9 moved past", v, 32'h0000_0442);
    chk("R9 still no fire", 32'(alarmIrq), 32'h0);

    // R11: unmapped writes ignored
    wr(4'h0, 8'h81);
    loadCnt(32'hCAFE_0123);
    setMatch(32'h0BAD_F00D);
    wr(4'hE, 8'hFF); wr(4'hF, 8'h00);
    rd(4'hE, d); chk("R11 read E", 32'(d), 32'h0);
    rd(4'hF, d); chk("R11 read F", 32'(d), 32'h0);
    rd(4'h0, d); chk("R11 ctrl kept", 32'(d), 32'h81);
    readCnt(v); chk("R11 count kept", v, 32'hCAFE_0123);
    readMatch(v); chk("R11 match kept", v, 32'h0BAD_F00D);
    chk("R11 irq kept", 32'(alarmIrq), 32'h0);

    // R12: ordered load with a tick every cycle
    wr(4'h0, 8'h80);
    loadCnt(32'h0000_00FE);
    @(negedge clk); tickIn = 1'b1;
    loadCnt(32'h1234_5678);
    tickIn = 1'b0;
    readCnt(v); chk("R12 exact after ordered load", v, 32'h1234_5678);

    // R13: torn read detection
    loadCnt(32'h0000_01FF);
    rd(4'h6, d0a);
    ticks(1);
    rd(4'h7, d1);
    rd(4'h6, d0b);
    chk("R13 first low", 32'(d0a), 32'hFF);
    chk("R13 upper after carry", 32'(d1), 32'h02);
    chk("R13 reread smaller", 32'(d0b < d0a), 32'h1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule